// File: doc/BRIEF.md
# Frame-Paced BCD Counter

This block keeps a four-digit decimal count in BCD that moves forward in step with video frames. A one-cycle frame pulse, derived elsewhere from the start of vertical blanking, is the only event that advances anything. An internal prescaler divides that pulse by sixty, so in normal operation the count rises by one for every sixty frames, roughly once a second.

A held fast-advance button bypasses the prescaler so that the count rises on every frame. A clear button zeroes the count, the prescaler and a status LED. That LED flips each time the prescaler completes a sixty-frame cycle. A second LED mirrors the blanking level, delayed by one clock. All decisions are taken in one prioritised chain on the system clock, qualified by the frame pulse. The blanking signal is never used as a clock.

Top module: `frame_bcd_counter`

## Requirements
- R1: While the asynchronous active-low reset is asserted, every digit reads 0 and both LEDs are low.
- R2: With fast-advance low, the count rises by exactly one on the frame pulse that completes every sixtieth frame since the last clear, and it holds on the other fifty-nine pulses.
- R3: The step LED inverts on each sixty-frame prescaler rollover and holds in every other cycle.
- R4: While fast-advance is high, every frame pulse adds one to the count. The prescaler keeps its value and the step LED does not change.
- R5: A high clear button on a clock edge sets the count, the prescaler and the step LED to zero. This takes priority over any frame pulse and over fast-advance in the same cycle.
- R6: digits_o carries digit i in bits [4i+3:4i], with digit 0 the least significant. Each nibble holds a value from 0 to 9, and a digit stepping past 9 returns to 0 and carries one into the next digit.
- R7: Advancing from 9999 gives 0000.
- R8: blank_led_o equals vblank_i as sampled on the previous clock edge.
- R9: In cycles with no frame pulse and no clear, the digits and the step LED hold, whatever the fast-advance and blanking inputs do.
- R10: A fast-advance interval freezes the prescaler. After release, the next rollover comes once the remaining frames of the interrupted cycle have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick_i | input | 1 | One-cycle pulse per frame, at the start of blanking |
| vblank_i | input | 1 | Vertical blanking level |
| clear_btn_i | input | 1 | Synchronous clear button, debounced |
| fast_btn_i | input | 1 | Fast-advance button, debounced |
| step_led_o | output | 1 | Toggles on each sixty-frame rollover |
| blank_led_o | output | 1 | Registered copy of the blanking level |
| digits_o | output | 16 | Four BCD digits, digit 0 in the low nibble |

## Verification
Two pairs of functions can meet in a single cycle. The first is a clear and a frame pulse. The bench raises the clear button together with a frame pulse and fast-advance, and also on the pulse that would otherwise be the sixtieth of a cycle. It then expects zeros and a full fresh sixty-frame wait before the next step. The second is fast-advance and a pending rollover. The bench holds fast-advance across the point where the prescaler would have wrapped. It judges the result by whether the later rollover arrives exactly after the frames that were still outstanding.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;

  // one decision per clock, chosen by a fixed priority
  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_CLEAR,
    CMD_FAST,
    CMD_ROLL,
    CMD_PRESCALE
  } fbc_cmd_e;
endpackage

// File: rtl/fbc_prescaler.sv
module fbc_prescaler #(
  parameter int LIMIT = 60,
  parameter int CNT_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last_o = (cnt_q == CNT_W'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (adv_i)
      cnt_d = last_o ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (clr_i || adv_i)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fbc_bcd_digit.sv
module fbc_bcd_digit
  import fbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output bcd_t val_o
);
  bcd_t val_q, val_d;

  assign val_o = val_q;

  always_comb begin
    val_d = val_q;
    if (clr_i)
      val_d = '0;
    else if (inc_i)
      val_d = (val_q == bcd_t'(9)) ? '0 : val_q + bcd_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      val_q <= '0;
    else if (clr_i || inc_i)
      val_q <= val_d;
  end
endmodule

// File: rtl/fbc_ctrl.sv
module fbc_ctrl
  import fbc_pkg::*;
(
  input  logic      clear_i,
  input  logic      tick_i,
  input  logic      fast_i,
  input  logic      pre_last_i,
  output fbc_cmd_e  cmd_o
);
  // clear beats fast-advance, which beats the prescaler path
  always_comb begin
    if (clear_i)
      cmd_o = CMD_CLEAR;
    else if (!tick_i)
      cmd_o = CMD_IDLE;
    else if (fast_i)
      cmd_o = CMD_FAST;
    else if (pre_last_i)
      cmd_o = CMD_ROLL;
    else
      cmd_o = CMD_PRESCALE;
  end
endmodule

// File: rtl/frame_bcd_counter.sv
module frame_bcd_counter
  import fbc_pkg::*;
#(
  parameter int FRAMES_PER_STEP = 60,
  parameter int NUM_DIGITS      = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        frame_tick_i,
  input  logic                        vblank_i,
  input  logic                        clear_btn_i,
  input  logic                        fast_btn_i,
  output logic                        step_led_o,
  output logic                        blank_led_o,
  output logic [NUM_DIGITS*BCD_W-1:0] digits_o
);
  localparam int PRE_W = (FRAMES_PER_STEP > 1) ? $clog2(FRAMES_PER_STEP) : 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      rst_pipe_q <= '0;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // decision
  fbc_cmd_e cmd;
  logic     pre_last;

  fbc_ctrl ctrl_i (
    .clear_i    (clear_btn_i),
    .tick_i     (frame_tick_i),
    .fast_i     (fast_btn_i),
    .pre_last_i (pre_last),
    .cmd_o      (cmd)
  );

  logic pre_clr, pre_adv, dig_clr, dig_step;

  always_comb begin
    pre_clr  = (cmd == CMD_CLEAR);
    dig_clr  = (cmd == CMD_CLEAR);
    pre_adv  = (cmd == CMD_ROLL) || (cmd == CMD_PRESCALE);
    dig_step = (cmd == CMD_ROLL) || (cmd == CMD_FAST);
  end

  fbc_prescaler #(
    .LIMIT (FRAMES_PER_STEP),
    .CNT_W (PRE_W)
  ) pre_i (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (pre_clr),
    .adv_i  (pre_adv),
    .last_o (pre_last)
  );

  // digit chain: a digit moves when every lower digit is at nine
  logic [NUM_DIGITS-1:0] inc_chain;
  assign inc_chain[0] = dig_step;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    fbc_bcd_digit dig_i (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .clr_i  (dig_clr),
      .inc_i  (inc_chain[g]),
      .val_o  (digits_o[g*BCD_W +: BCD_W])
    );
    if (g < NUM_DIGITS - 1) begin : g_carry
      assign inc_chain[g+1] = inc_chain[g] &&
                              (digits_o[g*BCD_W +: BCD_W] == bcd_t'(9));
    end
  end

  // LEDs
  logic led_q, led_d, led_en;

  always_comb begin
    led_en = (cmd == CMD_CLEAR) || (cmd == CMD_ROLL);
    led_d  = (cmd == CMD_CLEAR) ? 1'b0 : ~led_q;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)
      led_q <= 1'b0;
    else if (led_en)
      led_q <= led_d;
  end

  logic blank_q;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)
      blank_q <= 1'b0;
    else
      blank_q <= vblank_i;
  end

  assign step_led_o  = led_q;
  assign blank_led_o = blank_q;
endmodule

// File: rtl/frame_bcd_counter_chk.sv
module frame_bcd_counter_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick,
  input logic                    vblank,
  input logic                    clear,
  input logic                    fast,
  input logic                    step_led,
  input logic                    blank_led,
  input logic [NUM_DIGITS*4-1:0] digits
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  function automatic logic all_legal(logic [NUM_DIGITS*4-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++)
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R5
  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (digits == '0) && !step_led);

  // R4
  p_fast_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fast && !clear) |=> (digits != $past(digits)) && $stable(step_led));

  // R3
  p_led_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(tick && !fast)) |=> $stable(step_led));

  // R9
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(digits));

  // R8
  p_blank_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (blank_led == $past(vblank)));

  // R6
  p_bcd_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    all_legal(digits));
endmodule

bind frame_bcd_counter frame_bcd_counter_chk #(
  .NUM_DIGITS (NUM_DIGITS)
) chk_i (
  .clk       (clk_i),
  .rst_n     (rst_sync_n),
  .tick      (frame_tick_i),
  .vblank    (vblank_i),
  .clear     (clear_btn_i),
  .fast      (fast_btn_i),
  .step_led  (step_led_o),
  .blank_led (blank_led_o),
  .digits    (digits_o)
);

// File: tb/frame_bcd_counter_tb_top.sv
module frame_bcd_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        vblank = 1'b0;
  logic        clr = 1'b0;
  logic        fast = 1'b0;
  logic        step_led, blank_led;
  logic [15:0] digits;

  always #4 clk = ~clk;

  frame_bcd_counter dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_tick_i (tick),
    .vblank_i     (vblank),
    .clear_btn_i  (clr),
    .fast_btn_i   (fast),
    .step_led_o   (step_led),
    .blank_led_o  (blank_led),
    .digits_o     (digits)
  );

  typedef struct {
    logic [15:0] d;
    logic        led;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  int   m_val = 0;
  int   m_pre = 0;
  bit   m_led = 1'b0;
  logic pend = 1'b0;

  function automatic logic [15:0] to_bcd(int v);
    logic [15:0] r;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one event and pushes the expected outcome
  task automatic drive(bit tk, bit fs, bit cl, string tag);
    exp_t e;
    @(negedge clk);
    tick = tk; fast = fs; clr = cl;
    if (cl) begin
      m_val = 0; m_pre = 0; m_led = 1'b0;
    end else if (tk) begin
      if (fs) m_val = (m_val + 1) % 10000;
      else if (m_pre == 59) begin
        m_pre = 0; m_val = (m_val + 1) % 10000; m_led = ~m_led;
      end else m_pre++;
    end
    if (tk || cl) begin
      e.d = to_bcd(m_val); e.led = m_led; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      tick = 1'b0; clr = 1'b0;
    end
  endtask

  // monitor
  always @(posedge clk) pend <= tick | clr;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "queue underflow", 32'(digits), 32'hx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(digits == e.d, e.tag, 32'(digits), 32'(e.d));
        check(step_led == e.led, {e.tag, " led"}, 32'(step_led), 32'(e.led));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] hold_d;
    logic        hold_l;
    repeat (5) @(negedge clk);
    check(digits == 16'h0 && !step_led && !blank_led, "R1 reset state",
          {step_led, blank_led, digits}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 blanking LED
    vblank = 1'b1;
    @(negedge clk);
    check(blank_led == 1'b1, "R8 blank high", 32'(blank_led), 32'h1);
    vblank = 1'b0;
    @(negedge clk);
    check(blank_led == 1'b0, "R8 blank low", 32'(blank_led), 32'h0);

    // R2 R3 normal pace, back-to-back then sparse
    for (int i = 0; i < 70; i++) drive(1, 0, 0, "R2 R3 dense");
    for (int i = 0; i < 55; i++) begin
      drive(1, 0, 0, "R2 R3 sparse");
      idle(2);
    end
    idle(2);
    check(digits == 16'h0002 && !step_led, "R2 two steps",
          {step_led, digits}, 32'h0002);

    // R9 idle with moving inputs
    hold_d = digits; hold_l = step_led;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      fast = i[0]; vblank = i[1];
    end
    fast = 1'b0;
    @(negedge clk);
    check(digits == hold_d && step_led == hold_l, "R9 hold",
          {step_led, digits}, {hold_l, hold_d});

    // R10 fast interval freezes prescaler
    drive(0, 0, 1, "R5 clear");
    for (int i = 0; i < 30; i++) drive(1, 0, 0, "R10 before");
    for (int i = 0; i < 5; i++)  drive(1, 1, 0, "R10 fast");
    for (int i = 0; i < 29; i++) drive(1, 0, 0, "R10 after");
    idle(2);
    check(digits == 16'h0005 && !step_led, "R10 no early roll",
          {step_led, digits}, 32'h0005);
    drive(1, 0, 0, "R10 roll");
    idle(2);
    check(digits == 16'h0006 && step_led, "R10 roll point",
          {step_led, digits}, 32'h10006);

    // R5 clear against tick and fast, and against a pending roll
    drive(1, 1, 1, "R5 clear wins");
    for (int i = 0; i < 59; i++) drive(1, 0, 0, "R5 prep");
    drive(1, 0, 1, "R5 clear over roll");
    for (int i = 0; i < 59; i++) drive(1, 0, 0, "R5 fresh wait");
    idle(2);
    check(digits == 16'h0 && !step_led, "R5 no step",
          {step_led, digits}, 32'h0);
    drive(1, 0, 0, "R5 first roll");

    // R4 R6 fast advance and digit layout
    drive(0, 0, 1, "R5 clear");
    for (int i = 0; i < 100; i++) drive(1, 1, 0, "R4 fast");
    idle(2);
    check(digits == 16'h0100 && !step_led, "R6 layout",
          {step_led, digits}, 32'h0100);

    // R7 wrap
    for (int i = 0; i < 9899; i++) drive(1, 1, 0, "R4 R6 run");
    idle(2);
    check(digits == 16'h9999, "R7 top", 32'(digits), 32'h9999);
    drive(1, 1, 0, "R7 wrap");
    idle(2);
    check(digits == 16'h0000, "R7 wrap zero", 32'(digits), 32'h0);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule